// File: doc/BRIEF.md
# Fractional Divide-Ratio Modulator with Two-Tone Frequency Keying

This block sets the divide ratio of a fractional-N synthesizer's feedback divider, one value per reference cycle. A 35-bit fractional word is fed to three first-order accumulators connected in cascade. The overflow bits of the three stages go through a noise-cancelling difference network. The result is a small signed offset, and this offset is added to an integer divide value. Over many cycles the offsets average to the fractional word divided by 2^35. With a 10 MHz reference this sets the synthesized frequency in steps of about 0.29 mHz.

A slow external square wave selects which fractional word feeds the cascade. When the wave is low, the base word is used. When it is high, the base word plus a signed deviation is used, so the synthesized frequency is keyed between two tones. The square wave is asynchronous. It passes through two flip-flops, and the selected word is then registered whole at a clock edge, so no partly updated word ever reaches the accumulators. An enable input freezes the modulator state and pins the output to the integer value.

Top module: `fsk_mash_dsm`

## Requirements
- R1: While reset is held, and after it, every register clears to zero. The first output after reset (div_ratio) is 0.
- R2: When en is low at a clock edge, div_ratio after that edge equals int_word. The accumulators and overflow delay registers keep their values, so the offset sequence continues where it stopped once en returns high.
- R3: When the active fractional word is zero and the accumulators are zero, div_ratio equals int_word on every cycle.
- R4: The active word enters stage 1 of the 35-bit accumulator cascade. Each later stage adds the new residue of the stage before it, and each stage produces an overflow bit c1, c2 or c3. On the same edge, div_ratio becomes int_word + c1 + (c2 − c2 of the previous cycle) + (c3 − 2·c3 of the previous cycle + c3 of two cycles earlier).
- R5: Whenever en is high, the offset div_ratio − int_word lies between −3 and +4 inclusive.
- R6: The value of fsk_sq sampled at edge k selects the active word that the cascade uses at edge k+3. A low level selects frac_word and a high level selects frac_word + fsk_dev.
- R7: The keyed word frac_word + fsk_dev (fsk_dev is two's complement) clamps to 0 when negative. It clamps to 2^35 − 1 when it exceeds that value, and it never wraps.
- R8: Any frac_word, including 1 and 2^35 − 1, gives the exact sequence of R4. Changing int_word while running shifts div_ratio by the change from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Modulator enable; low freezes state and outputs int_word |
| int_word | input | INT_W (8) | Integer divide value, 3 or more |
| frac_word | input | FRAC_W (35) | Base fractional word |
| fsk_dev | input | DEV_W (24) | Signed deviation added when keyed high |
| fsk_sq | input | 1 | Asynchronous keying square wave |
| div_ratio | output | INT_W+1 (9) | Registered divide ratio for the current cycle |

## Verification
The assertions take int_word to be at least 3, so that a negative offset cannot make the output underflow. They also take fsk_dev to be no wider than the fractional word. The range check on the offset relies on the overflow bits being single bits from the internal accumulators. The bench keeps int_word between 3 and 250 and uses a 24-bit deviation. It drives fsk_sq on the falling edge, so that the synchronizer sees clean levels and the three-edge keying latency can be predicted. A behavioural model using 64-bit integers is compared against the output on every cycle.

// File: rtl/fsk_dsm_pkg.sv
package fsk_dsm_pkg;
    localparam int NSTAGE = 3;
    localparam int OFS_W  = 4;
    typedef logic signed [OFS_W-1:0] dsm_ofs_t;
endpackage

// File: rtl/fsk_word_sel.sv
module fsk_word_sel #(
    parameter int FRAC_W = 35,
    parameter int DEV_W  = 24
) (
    input  logic                    sel,
    input  logic [FRAC_W-1:0]       base,
    input  logic signed [DEV_W-1:0] dev,
    output logic [FRAC_W-1:0]       word
);
    localparam int SUM_W = FRAC_W + 2;

    logic signed [SUM_W-1:0] sum_w;
    logic [FRAC_W-1:0]       clamp_w;

    always_comb begin
        sum_w = $signed({2'b00, base}) + $signed({{(SUM_W-DEV_W){dev[DEV_W-1]}}, dev});
        if (sum_w[SUM_W-1]) begin
            clamp_w = '0;
        end else if (sum_w[FRAC_W]) begin
            clamp_w = '1;
        end else begin
            clamp_w = sum_w[FRAC_W-1:0];
        end
        word = sel ? clamp_w : base;
    end
endmodule

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
    parameter int FRAC_W = 35
) (
    input  logic [FRAC_W-1:0] acc_q,
    input  logic [FRAC_W-1:0] din,
    output logic [FRAC_W-1:0] sum,
    output logic              carry
);
    always_comb begin
        {carry, sum} = {1'b0, acc_q} + {1'b0, din};
    end
endmodule

// File: rtl/mash_cancel.sv
module mash_cancel
    import fsk_dsm_pkg::*;
(
    input  logic     c1,
    input  logic     c2,
    input  logic     c2_p1,
    input  logic     c3,
    input  logic     c3_p1,
    input  logic     c3_p2,
    output dsm_ofs_t ofs
);
    always_comb begin
        ofs = $signed({3'b000, c1})
            + $signed({3'b000, c2}) - $signed({3'b000, c2_p1})
            + $signed({3'b000, c3}) - $signed({2'b00, c3_p1, 1'b0})
            + $signed({3'b000, c3_p2});
    end
endmodule

// File: rtl/fsk_mash_dsm.sv
module fsk_mash_dsm
    import fsk_dsm_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 35,
    parameter int DEV_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [INT_W-1:0]        int_word,
    input  logic [FRAC_W-1:0]       frac_word,
    input  logic signed [DEV_W-1:0] fsk_dev,
    input  logic                    fsk_sq,
    output logic [INT_W:0]          div_ratio
);
    localparam int TOT_W = INT_W + 2;

    typedef struct packed {
        logic                          sq1;
        logic                          sq2;
        logic [FRAC_W-1:0]             fcw;
        logic [NSTAGE-1:0][FRAC_W-1:0] acc;
        logic                          c2_p1;
        logic                          c3_p1;
        logic                          c3_p2;
        logic [INT_W:0]                div;
    } dsm_state_t;

    dsm_state_t st_d, st_q;

    logic [FRAC_W-1:0]              word_w;
    logic [NSTAGE-1:0][FRAC_W-1:0]  stg_in;
    logic [NSTAGE-1:0][FRAC_W-1:0]  stg_sum;
    logic [NSTAGE-1:0]              stg_cy;
    dsm_ofs_t                       ofs_w;
    logic signed [TOT_W-1:0]        tot_w;

    fsk_word_sel #(.FRAC_W(FRAC_W), .DEV_W(DEV_W)) u_sel (
        .sel  (st_q.sq2),
        .base (frac_word),
        .dev  (fsk_dev),
        .word (word_w)
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stg_in[i] = st_q.fcw;
        end else begin : g_next
            assign stg_in[i] = stg_sum[i-1];
        end
        mash_acc_stage #(.FRAC_W(FRAC_W)) u_acc (
            .acc_q (st_q.acc[i]),
            .din   (stg_in[i]),
            .sum   (stg_sum[i]),
            .carry (stg_cy[i])
        );
    end

    mash_cancel u_cancel (
        .c1    (stg_cy[0]),
        .c2    (stg_cy[1]),
        .c2_p1 (st_q.c2_p1),
        .c3    (stg_cy[2]),
        .c3_p1 (st_q.c3_p1),
        .c3_p2 (st_q.c3_p2),
        .ofs   (ofs_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.sq1 = fsk_sq;
        st_d.sq2 = st_q.sq1;
        st_d.fcw = word_w;
        tot_w    = $signed({2'b00, int_word}) + $signed({{(TOT_W-OFS_W){ofs_w[OFS_W-1]}}, ofs_w});
        if (en) begin
            st_d.acc   = stg_sum;
            st_d.c2_p1 = stg_cy[1];
            st_d.c3_p1 = stg_cy[2];
            st_d.c3_p2 = st_q.c3_p1;
            st_d.div   = tot_w[INT_W:0];
        end else begin
            st_d.div   = {1'b0, int_word};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_ratio = st_q.div;
endmodule

// File: rtl/fsk_mash_dsm_chk.sv
module fsk_mash_dsm_chk
    import fsk_dsm_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 35,
    parameter int DEV_W  = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [INT_W-1:0]        int_word,
    input  logic [FRAC_W-1:0]       frac_word,
    input  logic signed [DEV_W-1:0] fsk_dev,
    input  logic [INT_W:0]          div_ratio,
    input  logic                    sel_s2,
    input  logic [FRAC_W-1:0]       fcw_q,
    input  logic [FRAC_W-1:0]       acc1_q,
    input  dsm_ofs_t                ofs
);
    // R2
    hold_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> div_ratio == {1'b0, $past(int_word)});

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || fcw_q == '0) |=> acc1_q == $past(acc1_q));

    // R5
    ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (ofs >= -3 && ofs <= 4));

    // R6
    base_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_s2 |=> fcw_q == $past(frac_word));

    // R7
    sat_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s2 && !fsk_dev[DEV_W-1]) |=> fcw_q >= $past(frac_word));

    // R7
    sat_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s2 && fsk_dev[DEV_W-1]) |=> fcw_q <= $past(frac_word));
endmodule

bind fsk_mash_dsm fsk_mash_dsm_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DEV_W(DEV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .int_word  (int_word),
    .frac_word (frac_word),
    .fsk_dev   (fsk_dev),
    .div_ratio (div_ratio),
    .sel_s2    (st_q.sq2),
    .fcw_q     (st_q.fcw),
    .acc1_q    (st_q.acc[0]),
    .ofs       (ofs_w)
);

// File: tb/fsk_mash_dsm_bench.sv
module fsk_mash_dsm_bench;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 35;
    localparam int DEV_W  = 24;
    localparam longint MOD  = 64'sd1 <<< FRAC_W;
    localparam longint MASK = MOD - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    en = 1'b0;
    logic [INT_W-1:0]        int_word = 8'd20;
    logic [FRAC_W-1:0]       frac_word = '0;
    logic signed [DEV_W-1:0] fsk_dev = '0;
    logic                    fsk_sq = 1'b0;
    logic [INT_W:0]          div_ratio;

    int checks = 0;
    int failures = 0;
    bit chk_on = 1'b0;
    string cur_req = "R1";

    fsk_mash_dsm #(.INT_W(INT_W), .FRAC_W(FRAC_W), .DEV_W(DEV_W)) u_fsk_mash_dsm (
        .clk(clk), .rst_n(rst_n), .en(en), .int_word(int_word), .frac_word(frac_word),
        .fsk_dev(fsk_dev), .fsk_sq(fsk_sq), .div_ratio(div_ratio)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    longint m_s1 = 0, m_s2 = 0, m_fcw = 0, m_a1 = 0, m_a2 = 0, m_a3 = 0;
    longint m_c2p = 0, m_c3p = 0, m_c3pp = 0, m_div = 0, m_int = 0, m_w = 0;
    longint t1, t2, t3, k1, k2, k3, y;
    bit m_en = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_fcw = 0; m_a1 = 0; m_a2 = 0; m_a3 = 0;
            m_c2p = 0; m_c3p = 0; m_c3pp = 0; m_div = 0; m_en = 1'b0;
        end else begin
            m_w = longint'(frac_word);
            if (m_s2 != 0) begin
                m_w = m_w + longint'(fsk_dev);
                if (m_w < 0) m_w = 0;
                if (m_w > MASK) m_w = MASK;
            end
            m_en = en;
            m_int = longint'(int_word);
            if (en) begin
                t1 = m_a1 + m_fcw;          k1 = t1 / MOD; t1 = t1 % MOD;
                t2 = m_a2 + t1;             k2 = t2 / MOD; t2 = t2 % MOD;
                t3 = m_a3 + t2;             k3 = t3 / MOD; t3 = t3 % MOD;
                y = k1 + k2 - m_c2p + k3 - 2 * m_c3p + m_c3pp;
                m_div = m_int + y;
                m_a1 = t1; m_a2 = t2; m_a3 = t3;
                m_c3pp = m_c3p; m_c3p = k3; m_c2p = k2;
            end else begin
                m_div = m_int;
            end
            m_fcw = m_w;
            m_s2 = m_s1;
            m_s1 = fsk_sq ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (longint'(div_ratio) != m_div) begin
                failures++;
                $display("FAIL %s div_ratio actual=%0d expected=%0d", cur_req, div_ratio, m_div);
            end
            if (m_en) begin
                checks++;
                if (longint'(div_ratio) - m_int < -3 || longint'(div_ratio) - m_int > 4) begin
                    failures++;
                    $display("FAIL R5 offset actual=%0d expected=-3..4", longint'(div_ratio) - m_int);
                end
            end
        end
    end

    task automatic run(input int n, input string req);
        cur_req = req;
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_run(input int n, input int half, input string req);
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i % half == 0) fsk_sq = ~fsk_sq;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: output cleared during reset
        checks++;
        if (div_ratio != '0) begin
            failures++;
            $display("FAIL R1 reset actual=%0d expected=0", div_ratio);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;
        run(1, "R1");
        en = 1'b1;
        // R3: zero fractional word
        run(20, "R3");
        // R4: general fractional word
        frac_word = 35'h1_2345_6789;
        run(300, "R4");
        // R8: extremes and integer change
        frac_word = 35'd1;
        run(50, "R8");
        frac_word = '1;
        run(80, "R8");
        int_word = 8'd3;
        frac_word = 35'h2_AAAA_5555;
        run(60, "R8");
        int_word = 8'd250;
        run(60, "R8");
        int_word = 8'd40;
        // R6: keying with positive deviation
        frac_word = 35'h0_8000_0000;
        fsk_dev = 24'sd3_000_000;
        toggle_run(200, 16, "R6");
        fsk_dev = -24'sd1_234_567;
        toggle_run(200, 7, "R6");
        // R7: saturation high and low
        fsk_sq = 1'b1;
        frac_word = 35'h7_FFFF_FF00;
        fsk_dev = 24'sd4_000_000;
        run(100, "R7");
        frac_word = 35'd1000;
        fsk_dev = -24'sd4_000_000;
        run(60, "R7");
        fsk_sq = 1'b0;
        // R2: enable low freezes state, then resumes
        frac_word = 35'h3_1415_9265;
        run(40, "R2");
        en = 1'b0;
        run(30, "R2");
        int_word = 8'd77;
        run(10, "R2");
        en = 1'b1;
        run(100, "R2");
        // R1: reset mid-run clears state
        rst_n = 1'b0;
        chk_on = 1'b0;
        run(3, "R1");
        checks++;
        if (div_ratio != '0) begin
            failures++;
            $display("FAIL R1 reset actual=%0d expected=0", div_ratio);
        end
        rst_n = 1'b1;
        chk_on = 1'b1;
        run(100, "R1");
        chk_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule